// File: doc/BRIEF.md
# Compare Flags and Branch Unit

This block sits in the control path of a small 16-bit processor. A compare operation gives it two operands. It reduces the outcome to two stored bits: one says the first operand was below the second, and the other says they were equal. No data register is written. A later conditional jump names one of eight selector codes. The unit reads the two stored bits, decides whether control transfers, and produces the instruction pointer the sequencer should load next.

On a taken jump the next pointer is the jump target. When the condition fails, the next pointer is the fall-through address, which is the address just past the jump. The registered taken flag tells the sequencer that the target load is needed, so a taken jump costs its one extra cycle and a jump that is not taken costs none. The eighth selector code has no jump assigned to it and is reported as illegal.

Top module: `cfb_unit`

## Requirements
- R1: After a synchronous active-low reset, `ip_next` is 0, `br_taken` is 0 and `bad_code` is 0. The stored flags are not-below and not-equal, so a selector-0 jump issued before any compare is taken and a selector-4 jump issued before any compare is not taken.
- R2: When `cmp_go` is high at a clock edge, the below flag takes the unsigned result `opnd_a < opnd_b` and the equal flag takes `opnd_a == opnd_b`. The two flags are never set together.
- R3: The flags keep their value until the next compare. Jumps and idle cycles leave them unchanged.
- R4: The condition selected by `jmp_sel` is tested against the stored flags with this encoding: 0 above (not below and not equal), 1 above-or-equal (not below), 2 below, 3 below-or-equal, 4 equal, 5 not-equal.
- R5: Selector 6 is unconditional. It always sets `br_taken` and loads `jmp_target` into `ip_next`.
- R6: A jump whose condition is false gives `br_taken` = 0 and `ip_next` = `ip_fall`.
- R7: Selector 7 is illegal. It gives `bad_code` = 1, `br_taken` = 0 and `ip_next` = `ip_fall`. Every legal jump clears `bad_code`.
- R8: The outputs are registered. They change at the clock edge that samples `jmp_go` high, and they hold their values on every cycle in which `jmp_go` is low.
- R9: When `cmp_go` and `jmp_go` are high on the same edge, the jump is judged on the flags from before that compare, and the new compare result applies to later jumps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_go | input | 1 | Compare strobe |
| opnd_a | input | 16 | First compare operand |
| opnd_b | input | 16 | Second compare operand |
| jmp_go | input | 1 | Jump strobe |
| jmp_sel | input | 3 | Jump condition selector |
| jmp_target | input | 16 | Jump destination address |
| ip_fall | input | 16 | Address following the jump |
| ip_next | output | 16 | Next instruction pointer |
| br_taken | output | 1 | Last jump transferred control |
| bad_code | output | 1 | Last jump used the unassigned selector |

## Verification
The flags have no output of their own, so their state can only be read from the decisions of later jumps. The bench therefore follows each compare with a sweep of all seven legal selectors, using distinct target and fall-through addresses so that both the flag bits and the mux choice can be told apart. It uses operand pairs whose unsigned and signed orderings disagree, such as 0 against 0xFFFF, and a jump issued before any compare to expose the reset flags. It also issues a compare and a jump on the same edge; the operands in that cycle are chosen to reverse the flags, so the old and the new flags would give opposite decisions.

// File: rtl/cfb_pkg.sv
// Package: shared selector encoding for the compare flags and branch unit.
// Assumes a 3-bit selector; the code order is what the condition decoder uses.
package cfb_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        J_ABOVE  = 3'd0,
        J_AEQ    = 3'd1,
        J_BELOW  = 3'd2,
        J_BEQ    = 3'd3,
        J_EQUAL  = 3'd4,
        J_NEQUAL = 3'd5,
        J_ALWAYS = 3'd6,
        J_NONE   = 3'd7
    } jcode_e;

    typedef struct packed {
        logic below;
        logic equal;
    } flags_t;
endpackage

// File: rtl/cfb_flag_store.sv
// Module: holds the unsigned below/equal outcome of the latest compare.
// Assumes operands are valid in the cycle cmp_go is high; the flags reset to
// not-below, not-equal and change only on a compare strobe.
module cfb_flag_store #(
    parameter int W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmp_go,
    input  logic [W-1:0]    opnd_a,
    input  logic [W-1:0]    opnd_b,
    output cfb_pkg::flags_t flags
);
    cfb_pkg::flags_t fresh;

    // Purpose: unsigned magnitude and equality of the two operands.
    always_comb begin
        fresh.below = (opnd_a < opnd_b);
        fresh.equal = (opnd_a == opnd_b);
    end

    // Purpose: capture the compare outcome on the strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (cmp_go) begin
            flags <= fresh;
        end
    end

    // R2: below and equal are mutually exclusive
    p_flags_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags.below && flags.equal));

    // R3: without a compare strobe the flags keep their value
    p_flags_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_go |=> $stable(flags));
endmodule

// File: rtl/cfb_cond_eval.sv
// Module: decides whether the selected jump is taken from the stored flags.
// Assumes flags come from cfb_flag_store; code J_NONE is never taken and is
// flagged as unassigned.
module cfb_cond_eval (
    input  cfb_pkg::flags_t             flags,
    input  logic [cfb_pkg::SEL_W-1:0]   sel,
    output logic                        take,
    output logic                        unassigned
);
    import cfb_pkg::*;

    localparam int NCODE = 1 << SEL_W;

    logic [NCODE-1:0] cond_vec;

    // Purpose: derive every condition from the two flag bits.
    always_comb begin
        cond_vec           = '0;
        cond_vec[J_ABOVE]  = !flags.below && !flags.equal;
        cond_vec[J_AEQ]    = !flags.below;
        cond_vec[J_BELOW]  = flags.below;
        cond_vec[J_BEQ]    = flags.below || flags.equal;
        cond_vec[J_EQUAL]  = flags.equal;
        cond_vec[J_NEQUAL] = !flags.equal;
        cond_vec[J_ALWAYS] = 1'b1;
        cond_vec[J_NONE]   = 1'b0;
    end

    // Purpose: pick the selected condition and mark the unassigned code.
    always_comb begin
        take       = cond_vec[sel];
        unassigned = (jcode_e'(sel) == J_NONE);
    end
endmodule

// File: rtl/cfb_ip_select.sv
// Module: registers the next instruction pointer and the jump status.
// Assumes take and unassigned are settled in the cycle jmp_go is high; all
// outputs hold between jump strobes.
module cfb_ip_select #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         jmp_go,
    input  logic         take,
    input  logic         unassigned,
    input  logic [W-1:0] jmp_target,
    input  logic [W-1:0] ip_fall,
    output logic [W-1:0] ip_next,
    output logic         br_taken,
    output logic         bad_code
);
    // Purpose: load target or fall-through address and status on a jump.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_next  <= '0;
            br_taken <= 1'b0;
            bad_code <= 1'b0;
        end else if (jmp_go) begin
            ip_next  <= take ? jmp_target : ip_fall;
            br_taken <= take;
            bad_code <= unassigned;
        end
    end

    // R6: a jump not taken yields the fall-through address
    p_fall_through_r6: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_go && !take |=> (ip_next == $past(ip_fall)) && !br_taken);

    // R7: an unassigned code is never taken
    p_illegal_not_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_go && unassigned |=> bad_code && !br_taken);

    // R8: outputs hold without a jump strobe
    p_outputs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !jmp_go |=> $stable(ip_next) && $stable(br_taken) && $stable(bad_code));
endmodule

// File: rtl/cfb_unit.sv
// Module: top of the compare flags and branch unit.
// Assumes one compare and one jump strobe at most per cycle; a jump in the
// same cycle as a compare sees the flags from before that compare.
module cfb_unit #(
    parameter int W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmp_go,
    input  logic [W-1:0]              opnd_a,
    input  logic [W-1:0]              opnd_b,
    input  logic                      jmp_go,
    input  logic [cfb_pkg::SEL_W-1:0] jmp_sel,
    input  logic [W-1:0]              jmp_target,
    input  logic [W-1:0]              ip_fall,
    output logic [W-1:0]              ip_next,
    output logic                      br_taken,
    output logic                      bad_code
);
    cfb_pkg::flags_t flags;
    logic            take;
    logic            unassigned;

    cfb_flag_store #(.W(W)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmp_go (cmp_go),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .flags  (flags)
    );

    cfb_cond_eval u_cond (
        .flags      (flags),
        .sel        (jmp_sel),
        .take       (take),
        .unassigned (unassigned)
    );

    cfb_ip_select #(.W(W)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .jmp_go     (jmp_go),
        .take       (take),
        .unassigned (unassigned),
        .jmp_target (jmp_target),
        .ip_fall    (ip_fall),
        .ip_next    (ip_next),
        .br_taken   (br_taken),
        .bad_code   (bad_code)
    );

    // R5: the unconditional code always loads the target
    p_always_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_go && (jmp_sel == 3'd6) |=> br_taken && (ip_next == $past(jmp_target)));

    // R7: legal codes clear the illegal indication
    p_legal_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_go && (jmp_sel != 3'd7) |=> !bad_code);
endmodule

// File: tb/cfb_unit_test.sv
module cfb_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_go = 1'b0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic        jmp_go = 1'b0;
    logic [2:0]  jmp_sel = '0;
    logic [15:0] jmp_target = '0;
    logic [15:0] ip_fall = '0;
    logic [15:0] ip_next;
    logic        br_taken;
    logic        bad_code;

    int checks = 0;
    int errors = 0;
    logic m_below = 1'b0;
    logic m_equal = 1'b0;

    always #10 clk = ~clk;

    cfb_unit uut (
        .clk(clk), .rst_n(rst_n), .cmp_go(cmp_go), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .jmp_go(jmp_go), .jmp_sel(jmp_sel),
        .jmp_target(jmp_target), .ip_fall(ip_fall), .ip_next(ip_next),
        .br_taken(br_taken), .bad_code(bad_code)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic model_take(input logic [2:0] s, input logic b, input logic e);
        case (s)
            3'd0: return !b && !e;
            3'd1: return !b;
            3'd2: return b;
            3'd3: return b || e;
            3'd4: return e;
            3'd5: return !e;
            3'd6: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic do_cmp(input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        cmp_go = 1'b1; opnd_a = a; opnd_b = b;
        @(posedge clk); #1;
        cmp_go = 1'b0;
        m_below = (a < b);
        m_equal = (a == b);
    endtask

    task automatic do_jump(input string req, input logic [2:0] s,
                           input logic [15:0] tgt, input logic [15:0] fall);
        logic t;
        @(negedge clk);
        jmp_go = 1'b1; jmp_sel = s; jmp_target = tgt; ip_fall = fall;
        @(posedge clk); #1;
        jmp_go = 1'b0;
        @(negedge clk);
        t = model_take(s, m_below, m_equal);
        check(req, "br_taken", {31'd0, br_taken}, {31'd0, t});
        check(req, "ip_next", {16'd0, ip_next}, {16'd0, t ? tgt : fall});
        check(req, "bad_code", {31'd0, bad_code}, {31'd0, s == 3'd7});
    endtask

    task automatic sweep(input string req, input logic [15:0] base);
        for (int s = 0; s < 7; s++)
            do_jump(req, 3'(s), base + 16'(s * 16), base + 16'h0100 + 16'(s));
    endtask

    task automatic t_reset;
        check("R1", "ip_next", {16'd0, ip_next}, 32'd0);
        check("R1", "br_taken", {31'd0, br_taken}, 32'd0);
        check("R1", "bad_code", {31'd0, bad_code}, 32'd0);
        do_jump("R1", 3'd0, 16'h1234, 16'h0011);
        do_jump("R1", 3'd4, 16'h2345, 16'h0022);
    endtask

    task automatic t_conditions;
        do_cmp(16'd5, 16'd9);       sweep("R4", 16'h1000);
        do_cmp(16'd9, 16'd5);       sweep("R4", 16'h2000);
        do_cmp(16'h7777, 16'h7777); sweep("R2", 16'h3000);
        do_cmp(16'h0000, 16'hFFFF); sweep("R2", 16'h4000);
        do_cmp(16'hFFFF, 16'h0000); sweep("R6", 16'h5000);
        do_cmp(16'h8000, 16'h7FFF); sweep("R5", 16'h6000);
    endtask

    task automatic t_illegal;
        do_cmp(16'd3, 16'd3);
        do_jump("R7", 3'd7, 16'hBEEF, 16'h0042);
        do_jump("R7", 3'd4, 16'hCAFE, 16'h0044);
    endtask

    task automatic t_hold;
        do_cmp(16'd1, 16'd2);
        do_jump("R8", 3'd2, 16'hABCD, 16'h0050);
        repeat (4) @(negedge clk);
        check("R8", "ip_next hold", {16'd0, ip_next}, 32'h0000ABCD);
        check("R8", "br_taken hold", {31'd0, br_taken}, 32'd1);
        do_jump("R3", 3'd6, 16'h0600, 16'h0060);
        do_jump("R3", 3'd7, 16'h0700, 16'h0070);
        sweep("R3", 16'h7000);
    endtask

    task automatic t_same_cycle;
        logic t;
        do_cmp(16'd10, 16'd20);
        @(negedge clk);
        cmp_go = 1'b1; opnd_a = 16'd20; opnd_b = 16'd20;
        jmp_go = 1'b1; jmp_sel = 3'd2; jmp_target = 16'h0900; ip_fall = 16'h0090;
        @(posedge clk); #1;
        cmp_go = 1'b0; jmp_go = 1'b0;
        @(negedge clk);
        t = model_take(3'd2, m_below, m_equal);
        check("R9", "old flags used", {31'd0, br_taken}, {31'd0, t});
        check("R9", "ip_next", {16'd0, ip_next}, 32'h00000900);
        m_below = 1'b0; m_equal = 1'b1;
        do_jump("R9", 3'd4, 16'h0A00, 16'h00A0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_conditions();
        t_illegal();
        t_hold();
        t_same_cycle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule